// File: doc/BRIEF.md
# Rate Trim Prescaler for a One-Second Tick

This block turns a 32.768 kHz clock enable into a one-second tick and corrects the long-term rate of that tick digitally. The oscillator is not touched. The block edits the count that the prescaler makes. Time is divided into correction windows of a fixed number of seconds. In the first second of each window, a signed trim value decides how many input pulses that second stretches or shrinks by. The step size is two pulses.

Each trim step moves the window total by two pulses. With the default sizes (32768 pulses per second, 20-second windows), one step is about 3.05 ppm, and the residual error after trimming is within ±1.5 ppm. A positive trim makes the prescaler skip increments, so the second consumes more input pulses and the clock loses time. A negative trim makes the prescaler increment by two, so the second consumes fewer input pulses and the clock gains time.

A one-cycle correction strobe marks the point where the correction for the current window has been fully applied. Downstream time and date counters advance on the tick output.

Top module: `rate_trim_unit`

## Requirements
- R1: While rst_ni is low, sec_tick_o and corr_o are 0. A new window starts at the first enable after reset.
- R2: With trim_i = 0, every second lasts exactly PRESCALE input enables, and corr_o never pulses.
- R3: With trim_i = N > 0, the first second of each window lasts PRESCALE + 2N enables, because 2N enables are skipped. The other WINDOW_SEC-1 seconds last PRESCALE enables each.
- R4: With trim_i = N < 0, the first second of each window lasts PRESCALE - 2|N| enables, because 2|N| enables each count twice. The other seconds last PRESCALE enables each.
- R5: The extreme trim codes work without loss: the largest positive code and the most negative two's complement code of TRIM_W bits. Each window has exactly WINDOW_SEC ticks and consumes WINDOW_SEC*PRESCALE + 2N enables.
- R6: trim_i is sampled at the first enable of each window. A change to trim_i after that enable has no effect until the next window.
- R7: When N ≠ 0, corr_o is a one-cycle pulse in the clock after the 2|N|-th enable of the window's first second. It pulses exactly once per window.
- R8: sec_tick_o is a one-cycle pulse in the clock after the enable that completes a second. It is never high without an enable in the previous cycle, and it never lasts two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | One-cycle enable per 32.768 kHz reference pulse |
| trim_i | input | TRIM_W | Signed trim in two-pulse steps, two's complement |
| sec_tick_o | output | 1 | Corrected one-second tick pulse |
| corr_o | output | 1 | Pulse when the window's correction is complete |

## Verification
The bench builds the block with PRESCALE=32, WINDOW_SEC=4 and TRIM_W=4, so the trim range is -8 to +7. These values make complete multi-window runs short enough that every second of every window can be measured in enables. They also bring both extreme trim codes into reach. With this trim range, the most negative code doubles every enable until the second ends, so the final double increment and the tick fall on the same enable. The enable spacing varies between patterns, which shows that only enables, not clocks, advance the count.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE   = 2'd0,
    ADJ_SKIP   = 2'd1,
    ADJ_DOUBLE = 2'd2
  } adj_e;
endpackage

// File: rtl/trim_prescaler.sv
module trim_prescaler
  import trim_pkg::*;
#(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  adj_e adj_i,
  output logic wrap_o,
  output logic tick_o
);
  localparam int unsigned CNT_W = $clog2(PRESCALE) + 1;

  logic [CNT_W-1:0] cnt_q, sum;
  logic [1:0]       inc;
  logic             tick_q;

  always_comb begin
    unique case (adj_i)
      ADJ_SKIP:   inc = 2'd0;
      ADJ_DOUBLE: inc = 2'd2;
      default:    inc = 2'd1;
    endcase
    sum    = cnt_q + CNT_W'(inc);
    wrap_o = en_i && (sum >= CNT_W'(PRESCALE));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap_o;
      if (en_i) cnt_q <= wrap_o ? sum - CNT_W'(PRESCALE) : sum;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/trim_window.sv
module trim_window
  import trim_pkg::*;
#(
  parameter int unsigned WINDOW_SEC = 20,
  parameter int unsigned TRIM_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wrap_i,
  input  logic [TRIM_W-1:0] trim_i,
  output adj_e              adj_o,
  output logic              corr_o
);
  localparam int unsigned SEC_W = (WINDOW_SEC > 2) ? $clog2(WINDOW_SEC) : 1;
  localparam int unsigned MAG_W = TRIM_W + 1;

  logic [SEC_W-1:0]  sec_q;
  logic              armed_q, slow_q, corr_q;
  logic [MAG_W-1:0]  rem_q, mag;
  logic [TRIM_W-1:0] abs_trim;
  logic              trim_slow, first_sec, cur_slow, active;

  always_comb begin
    trim_slow = !trim_i[TRIM_W-1];
    abs_trim  = trim_slow ? trim_i : (~trim_i + TRIM_W'(1));
    mag       = {abs_trim, 1'b0};
    first_sec = (sec_q == '0);
    cur_slow  = armed_q ? trim_slow : slow_q;
    active    = first_sec && (armed_q ? (mag != '0) : (rem_q != '0));
    if (!active)      adj_o = ADJ_NONE;
    else if (cur_slow) adj_o = ADJ_SKIP;
    else               adj_o = ADJ_DOUBLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q   <= '0;
      armed_q <= 1'b1;
      slow_q  <= 1'b1;
      rem_q   <= '0;
      corr_q  <= 1'b0;
    end else begin
      corr_q <= en_i && first_sec && !armed_q && (rem_q == MAG_W'(1));
      if (en_i) begin
        if (armed_q && first_sec) begin
          // trim is latched once per window, here
          armed_q <= 1'b0;
          slow_q  <= trim_slow;
          rem_q   <= (mag == '0) ? '0 : mag - MAG_W'(1);
        end else if (rem_q != '0) begin
          rem_q <= rem_q - MAG_W'(1);
        end
      end
      if (wrap_i) begin
        if (sec_q == SEC_W'(WINDOW_SEC - 1)) begin
          sec_q   <= '0;
          armed_q <= 1'b1;
        end else begin
          sec_q <= sec_q + SEC_W'(1);
        end
      end
    end
  end

  assign corr_o = corr_q;
endmodule

// File: rtl/rate_trim_unit.sv
module rate_trim_unit
  import trim_pkg::*;
#(
  parameter int unsigned PRESCALE   = 32768,
  parameter int unsigned WINDOW_SEC = 20,
  parameter int unsigned TRIM_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              sec_tick_o,
  output logic              corr_o
);
  adj_e adj;
  logic wrap;

  trim_window #(
    .WINDOW_SEC(WINDOW_SEC),
    .TRIM_W    (TRIM_W)
  ) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick_en_i),
    .wrap_i(wrap),
    .trim_i(trim_i),
    .adj_o (adj),
    .corr_o(corr_o)
  );

  trim_prescaler #(
    .PRESCALE(PRESCALE)
  ) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick_en_i),
    .adj_i (adj),
    .wrap_o(wrap),
    .tick_o(sec_tick_o)
  );
endmodule

// File: rtl/rate_trim_unit_chk.sv
module rate_trim_unit_chk #(
  parameter int unsigned PRESCALE   = 32768,
  parameter int unsigned TRIM_W     = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_en_i,
  input logic sec_tick_o,
  input logic corr_o
);
  // R5: full-range doubling must stay inside one second
  initial p_trim_range_r5: assert (4 * (2 ** (TRIM_W - 1)) <= PRESCALE);

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!sec_tick_o && !corr_o));

  p_tick_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> $past(tick_en_i));

  p_tick_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

  p_corr_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o |-> $past(tick_en_i));

  p_corr_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o |=> !corr_o);
endmodule

bind rate_trim_unit rate_trim_unit_chk #(
  .PRESCALE(PRESCALE),
  .TRIM_W  (TRIM_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_en_i (tick_en_i),
  .sec_tick_o(sec_tick_o),
  .corr_o    (corr_o)
);

// File: tb/rate_trim_unit_test.sv
`timescale 1ns/1ps
module rate_trim_unit_test;
  localparam int P = 32;
  localparam int W = 4;
  localparam int TW = 4;

  typedef struct {
    int    len;
    int    corr_at;
    string tag;
  } exp_t;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          en = 0;
  logic [TW-1:0] trim = '0;
  logic          tick, corr;

  int   checks = 0, errors = 0;
  exp_t q[$];
  int   cnt = 0;
  bit   seen = 0, prev_tick = 0;

  always #5 clk = ~clk;

  rate_trim_unit #(.PRESCALE(P), .WINDOW_SEC(W), .TRIM_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(en), .trim_i(trim),
    .sec_tick_o(tick), .corr_o(corr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      cnt = 0; seen = 0; prev_tick = 0;
    end else begin
      if (corr) begin
        if (q.size() == 0 || q[0].corr_at == 0) chk(0, "R7 unexpected corr", 1, 0);
        else chk(cnt == q[0].corr_at, "R7 corr position", cnt, q[0].corr_at);
        seen = 1;
      end
      if (tick) begin
        if (prev_tick) chk(0, "R8 tick width", 2, 1);
        if (q.size() == 0) chk(0, "R5 extra tick", 1, 0);
        else begin
          chk(cnt == q[0].len, q[0].tag, cnt, q[0].len);
          if (q[0].corr_at != 0) chk(seen, "R7 corr missing", 0, 1);
          void'(q.pop_front());
        end
        cnt = 0; seen = 0;
      end
      prev_tick = tick;
      if (en) cnt++;
    end
  end

  task automatic push_window(input int n);
    exp_t e;
    string t;
    t = (n == 0) ? "R2 second length" : (n > 0 ? "R3 stretched second" : "R4 shortened second");
    e.len = P + 2 * n; e.corr_at = (n < 0) ? -2 * n : 2 * n; e.tag = t;
    q.push_back(e);
    for (int s = 1; s < W; s++) begin
      e.len = P; e.corr_at = 0; e.tag = (n == 0) ? "R2 second length" : "R3 R4 plain second";
      q.push_back(e);
    end
  endtask

  task automatic run(input int n_first, input int n_rest, input int nwin, input int gap);
    int total = 0;
    rst_n = 0; en = 0;
    trim = TW'(n_first);
    q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tick == 0 && corr == 0, "R1 reset outputs", {tick, corr}, 0);
    @(posedge clk); #1 rst_n = 1;
    push_window(n_first);
    for (int w = 1; w < nwin; w++) push_window(n_rest);
    foreach (q[i]) total += q[i].len;
    for (int k = 0; k < total; k++) begin
      @(posedge clk); #1 en = 1;
      @(posedge clk); #1 en = 0;
      if (k == 0) trim = TW'(n_rest); // R6: change after the latch point
      repeat (gap - 1) @(posedge clk);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R5 R6 window tick count", q.size(), 0);
  endtask

  initial begin
    fork
      begin
        run(0, 0, 2, 1);    // R2
        run(3, 3, 3, 1);    // R3
        run(-3, -3, 3, 2);  // R4
        run(7, 7, 2, 1);    // R5 max positive
        run(-8, -8, 2, 3);  // R5 most negative
        run(2, -5, 3, 1);   // R6 sign change next window
        run(-1, 0, 2, 2);   // R6 R7 correction then none
      end
      begin
        #2_000_000;
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule